// File: doc/BRIEF.md
# Three-Port Parallel I/O Peripheral

This block hangs on an 8-bit processor bus and offers three byte-wide general-purpose ports. Two of them are plain byte ports. The third is split into a lower and an upper nibble, and each nibble has its own direction. Each port powers up as an input and drives nothing. Software turns ports into outputs by writing a configuration word to the control address. A second kind of control write changes a single bit of the third port without disturbing any of its other bits.

Every bus access is qualified by a chip select. Reads are combinational: the addressed value appears on `rd_data` in the same cycle, and `rd_en` is raised so that an external bus buffer can be enabled. Writes are taken on the rising clock edge on which select and write are both high. The pins and the stored values change just after that edge.

Top module: `tri_port_pio`

## Requirements
- R1: After reset all three ports are inputs: `pa_oe`, `pb_oe` and `pc_oe` are all zero and every stored output value is zero.
- R2: A control write (`sel`=00) whose bit 7 is 1 is a configuration word. Bit 0 makes port A an output, bit 1 port B, bit 2 the lower nibble of port C and bit 3 the upper nibble; a 1 means output. The output enables follow from the edge that takes the write. A read of `sel`=00 returns 0x80 with the four direction bits in bits 3:0.
- R3: The register select codes are fixed: `sel`=11 is port A data, 10 is port B data, 01 is port C data (all 8 bits) and 00 is control. A data write stores the byte, and that byte drives the pins of each part that is an output.
- R4: A control write of a value from 0x00 to 0x0F changes exactly one port C bit and leaves the directions unchanged.
- R5: In such a command, bit 0 is the new bit value (1 sets, 0 clears) and bits 3:1 give the index of the port C bit, from 0 to 7.
- R6: The two nibbles of port C are independent. One nibble can drive its stored bits while the other reads its pins.
- R7: A configuration word clears the stored values of all three ports to zero.
- R8: A read of a port part that is an input returns the pin values. A read of a part that is an output returns the stored value.
- R9: `rd_en` is high only while `cs` and `rd` are both high. While `rd_en` is low, `rd_data` is zero.
- R10: A control write of a value from 0x10 to 0x7F has no effect.
- R11: A write strobe while `cs` is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| sel | input | 2 | Register select |
| wr_data | input | 8 | Write data from the CPU |
| rd_data | output | 8 | Read data to the CPU |
| rd_en | output | 1 | Data bus output enable |
| pa_in | input | 8 | Port A pin values |
| pa_out | output | 8 | Port A drive values |
| pa_oe | output | 8 | Port A per-pin output enable |
| pb_in | input | 8 | Port B pin values |
| pb_out | output | 8 | Port B drive values |
| pb_oe | output | 8 | Port B per-pin output enable |
| pc_in | input | 8 | Port C pin values |
| pc_out | output | 8 | Port C drive values |
| pc_oe | output | 8 | Port C per-pin output enable |

## Verification
Read results are due in the same cycle as the request. The bench therefore raises `cs` and `rd` on a falling edge and samples `rd_data` and `rd_en` one nanosecond later, with no clock edge in between. Write results on the pins, enables and stored values are due one edge later. Each write is held across exactly one rising edge, and the bench compares everything at the following falling edge against its own model of latches and directions.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int PIO_DW = 8;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'b00,
        SEL_PORTC = 2'b01,
        SEL_PORTB = 2'b10,
        SEL_PORTA = 2'b11
    } pio_sel_e;

    localparam int DIR_A  = 0;
    localparam int DIR_B  = 1;
    localparam int DIR_CL = 2;
    localparam int DIR_CH = 3;
    localparam int DIR_W  = 4;
endpackage

// File: rtl/pio_decode.sv
module pio_decode
    import pio_pkg::*;
#(
    parameter int DW = PIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          wr,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wr_data,
    output logic          wr_a,
    output logic          wr_b,
    output logic          wr_c,
    output logic          wr_mode,
    output logic          wr_bit
);
    localparam int IDX_W = $clog2(DW);

    logic wr_hit;
    logic ctrl_hit;
    logic bit_field_ok;

    always_comb begin
        wr_hit       = cs && wr;
        ctrl_hit     = wr_hit && (pio_sel_e'(sel) == SEL_CTRL);
        bit_field_ok = (wr_data[DW-1:IDX_W+1] == '0);
        wr_a         = wr_hit && (pio_sel_e'(sel) == SEL_PORTA);
        wr_b         = wr_hit && (pio_sel_e'(sel) == SEL_PORTB);
        wr_c         = wr_hit && (pio_sel_e'(sel) == SEL_PORTC);
        wr_mode      = ctrl_hit && wr_data[DW-1];
        wr_bit       = ctrl_hit && bit_field_ok;
    end

    // R3 / R11: at most one register written per cycle, and never without select
    p_one_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_a, wr_b, wr_c, wr_mode, wr_bit}));
    p_no_write_unselected_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |-> !(wr_a || wr_b || wr_c || wr_mode || wr_bit));
endmodule

// File: rtl/pio_regs.sv
module pio_regs
    import pio_pkg::*;
#(
    parameter int DW = PIO_DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic             wr_c,
    input  logic             wr_mode,
    input  logic             wr_bit,
    input  logic [DW-1:0]    wr_data,
    output logic [DW-1:0]    a_q,
    output logic [DW-1:0]    b_q,
    output logic [DW-1:0]    c_q,
    output logic [DIR_W-1:0] dir_q
);
    localparam int IDX_W = $clog2(DW);

    typedef struct packed {
        logic [DW-1:0]    a;
        logic [DW-1:0]    b;
        logic [DW-1:0]    c;
        logic [DIR_W-1:0] dir;
    } regs_t;

    regs_t st_d, st_q;
    logic [IDX_W-1:0] bit_idx;

    always_comb begin
        st_d    = st_q;
        bit_idx = wr_data[IDX_W:1];
        if (wr_mode) begin
            st_d.dir = wr_data[DIR_W-1:0];
            st_d.a   = '0;
            st_d.b   = '0;
            st_d.c   = '0;
        end else if (wr_bit) begin
            st_d.c[bit_idx] = wr_data[0];
        end else begin
            if (wr_a) st_d.a = wr_data;
            if (wr_b) st_d.b = wr_data;
            if (wr_c) st_d.c = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign a_q   = st_q.a;
    assign b_q   = st_q.b;
    assign c_q   = st_q.c;
    assign dir_q = st_q.dir;

    p_bit_keeps_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit |=> $stable(dir_q));
    p_bit_single_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_bit |=> ($countones(c_q ^ $past(c_q)) <= 1));
    p_mode_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mode |=> (a_q == '0 && b_q == '0 && c_q == '0));
    p_data_keeps_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_a || wr_b || wr_c) |=> $stable(dir_q));
endmodule

// File: rtl/pio_rdmux.sv
module pio_rdmux
    import pio_pkg::*;
#(
    parameter int DW = PIO_DW
) (
    input  logic             cs,
    input  logic             rd,
    input  logic [1:0]       sel,
    input  logic [DIR_W-1:0] dir_q,
    input  logic [DW-1:0]    a_q,
    input  logic [DW-1:0]    b_q,
    input  logic [DW-1:0]    c_q,
    input  logic [DW-1:0]    pa_in,
    input  logic [DW-1:0]    pb_in,
    input  logic [DW-1:0]    pc_in,
    output logic [DW-1:0]    rd_data,
    output logic             rd_en
);
    localparam int HALF = DW / 2;

    logic [DW-1:0] a_view, b_view, c_view, ctrl_view, mux;

    always_comb begin
        a_view = dir_q[DIR_A] ? a_q : pa_in;
        b_view = dir_q[DIR_B] ? b_q : pb_in;
        c_view[HALF-1:0]  = dir_q[DIR_CL] ? c_q[HALF-1:0]  : pc_in[HALF-1:0];
        c_view[DW-1:HALF] = dir_q[DIR_CH] ? c_q[DW-1:HALF] : pc_in[DW-1:HALF];
        ctrl_view = '0;
        ctrl_view[DW-1] = 1'b1;
        ctrl_view[DIR_W-1:0] = dir_q;
        unique case (pio_sel_e'(sel))
            SEL_PORTA: mux = a_view;
            SEL_PORTB: mux = b_view;
            SEL_PORTC: mux = c_view;
            default:   mux = ctrl_view;
        endcase
        rd_en   = cs && rd;
        rd_data = rd_en ? mux : '0;
    end
endmodule

// File: rtl/tri_port_pio.sv
module tri_port_pio
    import pio_pkg::*;
#(
    parameter int DW = PIO_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs,
    input  logic          rd,
    input  logic          wr,
    input  logic [1:0]    sel,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          rd_en,
    input  logic [DW-1:0] pa_in,
    output logic [DW-1:0] pa_out,
    output logic [DW-1:0] pa_oe,
    input  logic [DW-1:0] pb_in,
    output logic [DW-1:0] pb_out,
    output logic [DW-1:0] pb_oe,
    input  logic [DW-1:0] pc_in,
    output logic [DW-1:0] pc_out,
    output logic [DW-1:0] pc_oe
);
    localparam int HALF = DW / 2;

    logic wr_a, wr_b, wr_c, wr_mode, wr_bit;
    logic [DW-1:0] a_q, b_q, c_q;
    logic [DIR_W-1:0] dir_q;

    pio_decode #(.DW(DW)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .sel(sel), .wr_data(wr_data),
        .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c), .wr_mode(wr_mode), .wr_bit(wr_bit)
    );

    pio_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_a(wr_a), .wr_b(wr_b), .wr_c(wr_c),
        .wr_mode(wr_mode), .wr_bit(wr_bit), .wr_data(wr_data),
        .a_q(a_q), .b_q(b_q), .c_q(c_q), .dir_q(dir_q)
    );

    pio_rdmux #(.DW(DW)) u_rd (
        .cs(cs), .rd(rd), .sel(sel), .dir_q(dir_q), .a_q(a_q), .b_q(b_q), .c_q(c_q),
        .pa_in(pa_in), .pb_in(pb_in), .pc_in(pc_in), .rd_data(rd_data), .rd_en(rd_en)
    );

    assign pa_out = a_q;
    assign pb_out = b_q;
    assign pc_out = c_q;
    assign pa_oe  = {DW{dir_q[DIR_A]}};
    assign pb_oe  = {DW{dir_q[DIR_B]}};
    assign pc_oe  = {{HALF{dir_q[DIR_CH]}}, {HALF{dir_q[DIR_CL]}}};

    // R9: enable never raised without a read request
    p_rden_needs_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (cs && rd));
endmodule

// File: tb/tri_port_pio_tb.sv
module tri_port_pio_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 0, rd = 0, wr = 0;
    logic [1:0] sel = 0;
    logic [7:0] wr_data = 0;
    logic [7:0] rd_data;
    logic rd_en;
    logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_a = 0, m_b = 0, m_c = 0;
    logic [3:0] m_dir = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tri_port_pio dut_i (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .sel(sel),
        .wr_data(wr_data), .rd_data(rd_data), .rd_en(rd_en),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic check(string req, string what, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [1:0] s);
        case (s)
            2'b11: return m_dir[0] ? m_a : pa_in;
            2'b10: return m_dir[1] ? m_b : pb_in;
            2'b01: return {m_dir[3] ? m_c[7:4] : pc_in[7:4], m_dir[2] ? m_c[3:0] : pc_in[3:0]};
            default: return {4'h8, m_dir};
        endcase
    endfunction

    function automatic void model_write(logic [1:0] s, logic [7:0] d);
        case (s)
            2'b11: m_a = d;
            2'b10: m_b = d;
            2'b01: m_c = d;
            default: begin
                if (d[7]) begin
                    m_dir = d[3:0]; m_a = 0; m_b = 0; m_c = 0;
                end else if (d[7:4] == 4'h0) begin
                    m_c[d[3:1]] = d[0];
                end
            end
        endcase
    endfunction

    task automatic bus_write(logic [1:0] s, logic [7:0] d, logic with_cs);
        @(negedge clk);
        cs = with_cs; wr = 1; sel = s; wr_data = d;
        @(negedge clk);
        cs = 0; wr = 0;
        if (with_cs) model_write(s, d);
    endtask

    task automatic check_all(string req);
        check(req, "pa_out", pa_out, m_a);
        check(req, "pb_out", pb_out, m_b);
        check(req, "pc_out", pc_out, m_c);
        check(req, "pa_oe", pa_oe, {8{m_dir[0]}});
        check(req, "pb_oe", pb_oe, {8{m_dir[1]}});
        check(req, "pc_oe", pc_oe, {{4{m_dir[3]}}, {4{m_dir[2]}}});
        for (int s = 0; s < 4; s++) begin
            cs = 1; rd = 1; sel = 2'(s);
            #1;
            check(req, "rd_data", rd_data, exp_read(2'(s)));
            check("R9", "rd_en high", {7'b0, rd_en}, 8'h01);
            cs = 0; rd = 0;
            #1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'h96;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_all("R1");

        // R9: rd without cs, cs without rd
        rd = 1; sel = 2'b11; #1;
        check("R9", "rd_en no cs", {7'b0, rd_en}, 8'h00);
        check("R9", "rd_data no cs", rd_data, 8'h00);
        rd = 0; cs = 1; #1;
        check("R9", "rd_en no rd", {7'b0, rd_en}, 8'h00);
        cs = 0;

        // R2 / R3: all outputs then port writes
        bus_write(2'b00, 8'h8F, 1);
        check_all("R2");
        bus_write(2'b11, 8'h5A, 1);
        bus_write(2'b10, 8'hC3, 1);
        bus_write(2'b01, 8'h81, 1);
        check_all("R3");

        // R11: writes without chip select
        bus_write(2'b11, 8'hFF, 0);
        bus_write(2'b00, 8'h80, 0);
        check_all("R11");

        // R10: ignored control values
        bus_write(2'b00, 8'h10, 1);
        bus_write(2'b00, 8'h7F, 1);
        bus_write(2'b00, 8'h3E, 1);
        check_all("R10");

        // R4 / R5: set bit 7, clear bit 0, set bit 3
        bus_write(2'b00, 8'h0F, 1);
        check_all("R5");
        bus_write(2'b00, 8'h00, 1);
        bus_write(2'b00, 8'h07, 1);
        check_all("R4");

        // R7: configuration clears latches
        bus_write(2'b00, 8'h8F, 1);
        check_all("R7");

        // R6: lower nibble output, upper input
        bus_write(2'b00, 8'h84, 1);
        bus_write(2'b01, 8'hE7, 1);
        pc_in = 8'h3C;
        check_all("R6");
        bus_write(2'b00, 8'h88, 1);
        bus_write(2'b00, 8'h0D, 1);
        check_all("R6");

        // R8: mixed directions with random pins and stimulus
        for (int i = 0; i < 400; i++) begin
            logic [1:0] s;
            logic [7:0] d;
            int k;
            k = $urandom_range(0, 9);
            s = 2'($urandom_range(0, 3));
            d = 8'($urandom);
            if (k < 2) begin s = 0; d[7] = 1; end
            else if (k < 4) begin s = 0; d[7:4] = 0; end
            bus_write(s, d, ($urandom_range(0, 7) != 0));
            pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
            check_all("R8");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule